// File: doc/BRIEF.md
# SDIO Read Wait Controller

This block produces the read wait signal on data line D2 of an SDIO bus while a card is sending data to the host. Once a read wait interval is requested, the block holds D2 low so the card pauses before its next data block. When the interval is cancelled, it drives D2 high for a single card clock and then lets go of the line. It can open an interval straight from idle, before any block has arrived. A request made while a block is still coming in is put off until that block's CRC has been received.

The block does not carry any data itself. It watches the data path status (block reception in progress, block CRC received) and the host's control bits. It drives D2 through a value output and an output enable. All of its timing is counted in card clock ticks, which arrive as a one-cycle enable `clk_en` in the system clock domain. A window flag tells the host when it may sample card interrupts on D1 during the wait. Tick counts are parameters: the lead-in before D2 goes low, the tail after a stop, and the length of the high pulse.

Top module: `sdio_rdwait_ctrl`

## Requirements
- R1: An interval starts from idle or from waiting for data on a `clk_en` tick only when all of these are 1: `dpath_en`, `sdio_mode_en`, `rw_start`, `dir_to_host`. At the same time `clkstop_sel` and `rw_stop` must both be 0.
- R2: D2 is driven low (`d2_oe`=1, `d2_out`=0) from the second tick after the tick that opened the interval.
- R3: While D2 is held low, a tick that sees `rw_stop`=1 keeps D2 low for two more ticks. On the tick after those, D2 is driven high (`d2_oe`=1, `d2_out`=1) for exactly one tick.
- R4: On the tick after the high pulse, D2 is released (`d2_oe`=0, `d2_out`=0) and the block goes back to waiting for data, with `irq_window`=0.
- R5: No interval opens while `blk_busy` is 1, or after a block began until a `crc_done` pulse arrives. The interval opens on the first tick after the `crc_done` pulse.
- R6: While `rw_stop` is 1, no new interval opens. This holds after a finished interval and also when start and stop are requested together. The interval opens on the first tick after `rw_stop` returns to 0.
- R7: `irq_window` is 1 from the opening tick through the tick of the high pulse, covering the lead-in, the low phase and the tail.
- R8: Outputs change only on cycles where `clk_en`=1. Any number of cycles without a tick leaves them unchanged.
- R9: A cycle with `rst`=1 returns the block to idle with `d2_oe`=0 and `irq_window`=0, whatever `clk_en` is.
- R10: A tick that sees `dpath_en`=0 returns the block to idle with D2 released, even in the middle of an interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | One-cycle card clock tick |
| dpath_en | input | 1 | Data path enabled |
| sdio_mode_en | input | 1 | SDIO-specific operations enabled |
| rw_start | input | 1 | Read wait start request |
| rw_stop | input | 1 | Read wait stop request |
| clkstop_sel | input | 1 | Clock-stopping wait method selected (blocks this method) |
| dir_to_host | input | 1 | Transfer direction is card to host |
| blk_busy | input | 1 | A data block is being received |
| crc_done | input | 1 | Pulse: CRC of the current block received |
| d2_out | output | 1 | Value driven on D2 |
| d2_oe | output | 1 | Output enable for D2 |
| irq_window | output | 1 | D1 interrupt sampling allowed |

## Verification
Two things can meet on one card clock tick: the lead-in of a freshly opened interval can run into a data path disable, and the block hold-off can end just as a start request is waiting. The bench sets up both. It holds `rw_start` high through a whole block reception and pulses `crc_done` between ticks, then expects the interval to open on the next tick and no earlier. It then drops `dpath_en` while the controller is still in its lead-in, and expects D2 released and the window closed on that same tick. A separate case raises start and stop together and expects no interval until stop falls.

// File: rtl/sdio_rdwait_pkg.sv
package sdio_rdwait_pkg;
   typedef enum logic [2:0] {
      RW_IDLE = 3'd0,
      RW_WAIT = 3'd1,
      RW_LEAD = 3'd2,
      RW_HOLD = 3'd3,
      RW_TAIL = 3'd4,
      RW_REL  = 3'd5
   } rw_state_t;
endpackage

// File: rtl/rdwait_gate.sv
module rdwait_gate #(
   parameter bit HOLD_UNTIL_CRC = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic dpath_en,
   input  logic sdio_mode_en,
   input  logic rw_start,
   input  logic rw_stop,
   input  logic clkstop_sel,
   input  logic dir_to_host,
   input  logic blk_busy,
   input  logic crc_done,
   output logic busy_hold,
   output logic may_start
);
   generate
      if (HOLD_UNTIL_CRC) begin : g_crc
         logic in_block_q;
         always_ff @(posedge clk) begin
            if (rst)           in_block_q <= 1'b0;
            else if (crc_done) in_block_q <= 1'b0;
            else if (blk_busy) in_block_q <= 1'b1;
         end
         assign busy_hold = blk_busy | in_block_q;

         // R5: once a block begins, the hold stays until a CRC pulse
         p_hold_until_crc_r5: assert property (@(posedge clk) disable iff (rst)
            (blk_busy && !crc_done) |=> busy_hold);
      end else begin : g_level
         assign busy_hold = blk_busy;
      end
   endgenerate

   assign may_start = dpath_en & sdio_mode_en & rw_start & ~rw_stop &
                      ~clkstop_sel & dir_to_host & ~busy_hold;
endmodule

// File: rtl/rdwait_tick_cnt.sv
module rdwait_tick_cnt #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] count
);
   generate
      if (W < 1) begin : g_bad_w
         $error("rdwait_tick_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) count <= '0;
      else if (adv)   count <= count + 1'b1;
   end
endmodule

// File: rtl/rdwait_fsm.sv
module rdwait_fsm
   import sdio_rdwait_pkg::*;
#(
   parameter int LEAD_TICKS    = 2,
   parameter int TAIL_TICKS    = 2,
   parameter int RELEASE_TICKS = 1,
   parameter int CNT_W         = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             dpath_en,
   input  logic             dir_to_host,
   input  logic             may_start,
   input  logic             rw_stop,
   input  logic [CNT_W-1:0] cnt,
   output logic             cnt_clr,
   output logic             cnt_adv,
   output rw_state_t        state_q
);
   localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_TICKS - 1);
   localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_TICKS - 1);
   localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(RELEASE_TICKS - 1);

   rw_state_t state_d;

   always_comb begin
      state_d = state_q;
      if (tick) begin
         unique case (state_q)
            RW_IDLE: begin
               if (may_start)                     state_d = RW_LEAD;
               else if (dpath_en && dir_to_host)  state_d = RW_WAIT;
            end
            RW_WAIT: begin
               if (!dpath_en)      state_d = RW_IDLE;
               else if (may_start) state_d = RW_LEAD;
            end
            RW_LEAD: begin
               if (!dpath_en)             state_d = RW_IDLE;
               else if (cnt == LEAD_LAST) state_d = RW_HOLD;
            end
            RW_HOLD: begin
               if (!dpath_en)    state_d = RW_IDLE;
               else if (rw_stop) state_d = RW_TAIL;
            end
            RW_TAIL: begin
               if (!dpath_en)             state_d = RW_IDLE;
               else if (cnt == TAIL_LAST) state_d = RW_REL;
            end
            RW_REL: begin
               if (!dpath_en)            state_d = RW_IDLE;
               else if (cnt == REL_LAST) state_d = RW_WAIT;
            end
            default: state_d = RW_IDLE;
         endcase
      end
   end

   assign cnt_clr = (state_d != state_q);
   assign cnt_adv = tick && !cnt_clr &&
                    (state_q == RW_LEAD || state_q == RW_TAIL || state_q == RW_REL);

   always_ff @(posedge clk) begin
      if (rst) state_q <= RW_IDLE;
      else     state_q <= state_d;
   end

   // R8: no state movement between card clock ticks
   p_stable_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(state_q));

   // R3: the low phase only ends through the tail when the data path stays on
   p_hold_exit_r3: assert property (@(posedge clk) disable iff (rst)
      (state_q == RW_HOLD && tick && dpath_en && rw_stop) |=> state_q == RW_TAIL);

   // R4: release always returns to waiting for data
   p_rel_to_wait_r4: assert property (@(posedge clk) disable iff (rst)
      (state_q == RW_REL && $changed(state_q) == 1'b0 && state_d != RW_REL && dpath_en)
      |=> state_q == RW_WAIT);
endmodule

// File: rtl/sdio_rdwait_ctrl.sv
module sdio_rdwait_ctrl
   import sdio_rdwait_pkg::*;
#(
   parameter int LEAD_TICKS     = 2,
   parameter int TAIL_TICKS     = 2,
   parameter int RELEASE_TICKS  = 1,
   parameter bit HOLD_UNTIL_CRC = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic clk_en,
   input  logic dpath_en,
   input  logic sdio_mode_en,
   input  logic rw_start,
   input  logic rw_stop,
   input  logic clkstop_sel,
   input  logic dir_to_host,
   input  logic blk_busy,
   input  logic crc_done,
   output logic d2_out,
   output logic d2_oe,
   output logic irq_window
);
   localparam int MAX_TICKS = (LEAD_TICKS > TAIL_TICKS) ?
      ((LEAD_TICKS > RELEASE_TICKS) ? LEAD_TICKS : RELEASE_TICKS) :
      ((TAIL_TICKS > RELEASE_TICKS) ? TAIL_TICKS : RELEASE_TICKS);
   localparam int CNT_W = $clog2(MAX_TICKS + 1);

   generate
      if (LEAD_TICKS < 1 || TAIL_TICKS < 1 || RELEASE_TICKS < 1) begin : g_bad_ticks
         $error("sdio_rdwait_ctrl: every tick count must be at least 1");
      end
      if (MAX_TICKS > 255) begin : g_big_ticks
         $error("sdio_rdwait_ctrl: tick counts above 255 are not supported");
      end
   endgenerate

   logic             may_start;
   logic             busy_hold;
   logic             cnt_clr;
   logic             cnt_adv;
   logic [CNT_W-1:0] cnt;
   rw_state_t        state_q;

   rdwait_gate #(.HOLD_UNTIL_CRC(HOLD_UNTIL_CRC)) u_gate (
      .clk          (clk),
      .rst          (rst),
      .dpath_en     (dpath_en),
      .sdio_mode_en (sdio_mode_en),
      .rw_start     (rw_start),
      .rw_stop      (rw_stop),
      .clkstop_sel  (clkstop_sel),
      .dir_to_host  (dir_to_host),
      .blk_busy     (blk_busy),
      .crc_done     (crc_done),
      .busy_hold    (busy_hold),
      .may_start    (may_start)
   );

   rdwait_tick_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (cnt_clr),
      .adv   (cnt_adv),
      .count (cnt)
   );

   rdwait_fsm #(
      .LEAD_TICKS    (LEAD_TICKS),
      .TAIL_TICKS    (TAIL_TICKS),
      .RELEASE_TICKS (RELEASE_TICKS),
      .CNT_W         (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .tick        (clk_en),
      .dpath_en    (dpath_en),
      .dir_to_host (dir_to_host),
      .may_start   (may_start),
      .rw_stop     (rw_stop),
      .cnt         (cnt),
      .cnt_clr     (cnt_clr),
      .cnt_adv     (cnt_adv),
      .state_q     (state_q)
   );

   assign d2_oe      = (state_q == RW_HOLD) || (state_q == RW_TAIL) || (state_q == RW_REL);
   assign d2_out     = (state_q == RW_REL);
   assign irq_window = (state_q == RW_LEAD) || d2_oe;

   // R9: reset releases the line and closes the window
   p_reset_release_r9: assert property (@(posedge clk)
      rst |=> (!d2_oe && !irq_window));

   // R1: a window opens only under the full set of entry conditions
   p_entry_cond_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_window) |-> $past(dpath_en && sdio_mode_en && rw_start && !rw_stop &&
                                  !clkstop_sel && dir_to_host && clk_en));

   // R5: no window opens while a block is still arriving
   p_no_open_in_block_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_window) |-> $past(!blk_busy));

   // R3: the high level always follows a low level
   p_high_after_low_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(d2_out) |-> $past(d2_oe && !d2_out));

   // R10: a tick with the data path off releases D2
   p_disable_release_r10: assert property (@(posedge clk) disable iff (rst)
      (clk_en && !dpath_en) |=> (!d2_oe && !irq_window));

   // R2: D2 is never driven before the lead-in has run
   p_lead_before_low_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(d2_oe) |-> $past(irq_window && !d2_oe));

   generate
      if (RELEASE_TICKS == 1) begin : g_single_release
         // R4: a single-tick high pulse is followed by a released line
         p_release_single_r4: assert property (@(posedge clk) disable iff (rst)
            (d2_out && clk_en) |=> !d2_oe);
      end
   endgenerate
endmodule

// File: tb/sdio_rdwait_ctrl_test.sv
module sdio_rdwait_ctrl_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_en = 1'b0;
   logic dpath_en = 1'b0;
   logic sdio_mode_en = 1'b0;
   logic rw_start = 1'b0;
   logic rw_stop = 1'b0;
   logic clkstop_sel = 1'b0;
   logic dir_to_host = 1'b0;
   logic blk_busy = 1'b0;
   logic crc_done = 1'b0;
   logic d2_out, d2_oe, irq_window;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sdio_rdwait_ctrl uut (
      .clk(clk), .rst(rst), .clk_en(clk_en), .dpath_en(dpath_en),
      .sdio_mode_en(sdio_mode_en), .rw_start(rw_start), .rw_stop(rw_stop),
      .clkstop_sel(clkstop_sel), .dir_to_host(dir_to_host), .blk_busy(blk_busy),
      .crc_done(crc_done), .d2_out(d2_out), .d2_oe(d2_oe), .irq_window(irq_window)
   );

   // observed vector: {irq_window, d2_oe, d2_out}
   task automatic expect_out(input string req, input logic [2:0] exp);
      logic [2:0] act;
      act = {irq_window, d2_oe, d2_out};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got {win,oe,out}=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one card clock tick, followed by one idle system cycle
   task automatic tick();
      @(negedge clk) clk_en = 1'b1;
      @(negedge clk) clk_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic all_eligible();
      dpath_en = 1'b1; sdio_mode_en = 1'b1; dir_to_host = 1'b1;
      clkstop_sel = 1'b0; rw_stop = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      expect_out("R9 reset state", 3'b000);
   endtask

   task automatic t_full_cycle();
      all_eligible();
      rw_start = 1'b1;
      tick(); expect_out("R1 open from idle", 3'b100);
      tick(); expect_out("R7 lead-in window", 3'b100);
      tick(); expect_out("R2 D2 low after two ticks", 3'b110);
      rw_stop = 1'b1;
      tick(); expect_out("R3 tail tick 1 low", 3'b110);
      tick(); expect_out("R3 tail tick 2 low", 3'b110);
      tick(); expect_out("R3 high pulse", 3'b111);
      tick(); expect_out("R4 released after pulse", 3'b000);
      tick(); expect_out("R6 stop still set blocks restart", 3'b000);
      rw_stop = 1'b0;
      tick(); expect_out("R6 opens once stop clears", 3'b100);
      rw_start = 1'b0;
      dpath_en = 1'b0;
      tick(); expect_out("R10 disable during lead-in", 3'b000);
   endtask

   task automatic t_gating();
      do_reset();
      all_eligible();
      rw_start = 1'b1;
      tick(); expect_out("R8 open", 3'b100);
      idle_cycles(6); expect_out("R8 no change without tick (lead)", 3'b100);
      tick(); tick(); expect_out("R8 low after two ticks", 3'b110);
      rw_stop = 1'b1; rw_start = 1'b0;
      idle_cycles(5); expect_out("R8 stop waits for a tick", 3'b110);
      tick(); tick(); tick(); expect_out("R8 R3 pulse on third tick", 3'b111);
      idle_cycles(4); expect_out("R8 pulse held until next tick", 3'b111);
      tick(); expect_out("R4 released", 3'b000);
      rw_stop = 1'b0;
   endtask

   task automatic t_block_holdoff();
      all_eligible();
      rw_start = 1'b0;
      tick();
      blk_busy = 1'b1; rw_start = 1'b1;
      tick(); expect_out("R5 no open during block", 3'b000);
      tick(); expect_out("R5 still held during block", 3'b000);
      blk_busy = 1'b0;
      tick(); expect_out("R5 held until CRC", 3'b000);
      @(negedge clk) crc_done = 1'b1;
      @(negedge clk) crc_done = 1'b0;
      tick(); expect_out("R5 opens after CRC", 3'b100);
      dpath_en = 1'b0;
      tick(); expect_out("R10 disable aborts lead-in", 3'b000);
      rw_start = 1'b0;
   endtask

   task automatic t_conditions();
      do_reset();
      all_eligible();
      rw_start = 1'b1;
      clkstop_sel = 1'b1;
      tick(); expect_out("R1 clock-stop method blocks", 3'b000);
      clkstop_sel = 1'b0; dir_to_host = 1'b0;
      tick(); expect_out("R1 host-to-card blocks", 3'b000);
      dir_to_host = 1'b1; sdio_mode_en = 1'b0;
      tick(); expect_out("R1 mode disabled blocks", 3'b000);
      sdio_mode_en = 1'b1;
      tick(); expect_out("R1 opens with all set", 3'b100);
      tick(); tick(); expect_out("R2 low", 3'b110);
      do_reset();
      expect_out("R9 reset mid-interval without tick", 3'b000);
      rw_start = 1'b0;
   endtask

   task automatic t_stop_first();
      do_reset();
      all_eligible();
      rw_stop = 1'b1; rw_start = 1'b1;
      tick(); expect_out("R6 start with stop set", 3'b000);
      tick(); expect_out("R6 still blocked", 3'b000);
      rw_stop = 1'b0;
      tick(); expect_out("R6 opens after stop clears", 3'b100);
      tick(); tick(); expect_out("R2 low in second run", 3'b110);
      dpath_en = 1'b0;
      tick(); expect_out("R10 disable during low phase", 3'b000);
      rw_start = 1'b0;
   endtask

   initial begin
      idle_cycles(3);
      t_reset();
      t_full_cycle();
      t_gating();
      t_block_holdoff();
      t_conditions();
      t_stop_first();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule